// File: doc/BRIEF.md
# Parallel-Lag Cross-Correlation Engine

This block evaluates the discrete cross-correlation R(τ) = Σ x(n)·y(n−τ) of two finite signed integer signals of length SIG_LEN, for lags 0 through NUM_LAGS−1. It works in passes and computes LANES lags side by side in each pass. Each pass consumes exactly SIG_LEN sample pairs, one per accepted clock. Auto-correlation is obtained by feeding the same signal on both streams.

Two sample streams enter together under one qualifier. The reference stream (`in_ref`) carries x(0..SIG_LEN−1) unchanged on every pass. The shifted stream (`in_shf`) carries y delayed by the base lag of the pass, q·LANES, with zeros in the vacated leading slots, truncated to SIG_LEN samples. A short shift window keeps the most recent LANES shifted samples. Every reference sample is multiplied against all window taps at once, and each product goes into its own lane accumulator.

When the last sample of a pass is accepted, the lane totals are captured into an output holding register. They then leave one per clock in ascending lag order while the next pass is already being accumulated. A host builds the two streams and collects the results.

Top module: `corr_engine`

## Requirements
- R1: After reset `out_valid` and `out_last` are low, and they stay low until the final sample of a pass has been accepted.
- R2: In pass q (q counting from 0 after reset), lane j produces R(q·LANES+j) = Σ over n in 0..SIG_LEN−1 of x(n)·y(n−q·LANES−j), with y taken as zero outside 0..SIG_LEN−1. The sum is exact in signed two's complement of ACC_W bits.
- R3: The results of a pass appear on consecutive cycles, starting on the cycle after the pass's last sample is accepted. They come out in ascending lag order, and `out_lag` carries the lag as an unsigned binary number.
- R4: `out_last` is high exactly when the result for lag NUM_LAGS−1 is presented.
- R5: A cycle with `in_valid` low changes no state. The values on `in_ref` and `in_shf` in such a cycle have no effect on any later result.
- R6: At the first sample of every pass, the shift window and all lane accumulators restart from zero, so nothing from an earlier pass leaks into the next.
- R7: A new pass may start on the cycle right after the previous pass ends, with no idle cycles between passes, provided SIG_LEN ≥ LANES.
- R8: After pass NUM_LAGS/LANES−1 the engine returns to pass 0, so a following correlation begins again at lag 0 with no reset.
- R9: With identical streams (auto-correlation), lag 0 equals the sum of squares of the signal.
- R10: Full-scale inputs of −32768 on both streams accumulate without wrap for ACC_W = 40 and SIG_LEN up to 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Both stream samples are present this cycle |
| in_ref | input | DATA_W | Reference stream sample x(k), signed |
| in_shf | input | DATA_W | Shifted stream sample y(k−q·LANES) or zero padding, signed |
| out_valid | output | 1 | A lag result is presented |
| out_lag | output | LAG_W | Lag index of the presented result |
| out_data | output | ACC_W | Correlation value, signed |
| out_last | output | 1 | Marks the result for the highest lag |

## Verification
The bench builds the engine with SIG_LEN = 5, LANES = 4 and NUM_LAGS = 8. This gives two passes per correlation, and the output drain of four cycles fits inside a five-sample pass, so back-to-back passes and back-to-back correlations overlap the drain with new accumulation. With lags from 5 to 7 at or beyond the signal length, the zero-padding path that must yield exact zeros is also exercised. A short signal keeps runs brief, and the full-scale case still drives accumulators past 32 bits.

// File: rtl/corr_pkg.sv
package corr_pkg;

    // Default widths of the engine.
    localparam int CORR_DATA_W = 16;
    localparam int CORR_ACC_W  = 40;

    // Per-cycle sequencing qualifiers derived from the pass position.
    typedef struct packed {
        logic valid;   // a sample pair is accepted this cycle
        logic first;   // it is the first sample of a pass
        logic last;    // it is the last sample of a pass
    } corr_step_t;

endpackage

// File: rtl/corr_window.sv
// Shift window over the shifted stream. taps_o shows the contents
// after the current shift, so tap j carries the sample of j steps ago.
module corr_window #(
    parameter int DATA_W = 16,
    parameter int LANES  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_i,
    input  logic                          clear_i,
    input  logic [DATA_W-1:0]             din_i,
    output logic [LANES-1:0][DATA_W-1:0]  taps_o
);

    typedef struct packed {
        logic [LANES-1:0][DATA_W-1:0] cells;
    } win_t;

    win_t win_d, win_q;
    logic [LANES-1:0][DATA_W-1:0] taps_v;

    always_comb begin
        taps_v[0] = din_i;
        for (int j = 1; j < LANES; j++) begin
            taps_v[j] = clear_i ? '0 : win_q.cells[j-1];
        end
        win_d = win_q;
        if (shift_i) begin
            win_d.cells = taps_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign taps_o = taps_v;

    generate
        if (LANES > 1) begin : g_clear_chk
            // R6: a pass start leaves only the newest sample in the window
            p_clear_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_i && clear_i) |=> (win_q.cells[1] == '0));
        end
    endgenerate

endmodule

// File: rtl/corr_lanes.sv
// Multiply-accumulate array: one reference sample against every tap.
module corr_lanes #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40,
    parameter int LANES  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          valid_i,
    input  logic                          first_i,
    input  logic [DATA_W-1:0]             ref_i,
    input  logic [LANES-1:0][DATA_W-1:0]  taps_i,
    output logic [LANES-1:0][ACC_W-1:0]   sums_o
);

    localparam int PROD_W = 2 * DATA_W;

    typedef struct packed {
        logic [LANES-1:0][ACC_W-1:0] acc;
    } lanes_t;

    lanes_t lanes_d, lanes_q;
    logic signed [PROD_W-1:0] prod [LANES];
    logic [LANES-1:0][ACC_W-1:0] sum_v;

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_mul
            assign prod[j] = $signed(ref_i) * $signed(taps_i[j]);
        end
    endgenerate

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            sum_v[j] = (first_i ? '0 : lanes_q.acc[j]) + ACC_W'(prod[j]);
        end
        lanes_d = lanes_q;
        if (valid_i) begin
            lanes_d.acc = sum_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lanes_q <= '0;
        end else begin
            lanes_q <= lanes_d;
        end
    end

    assign sums_o = sum_v;

    generate
        if (LANES > 1) begin : g_restart_chk
            // R6: the highest lane sees only a cleared tap on the first sample
            p_lane_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_i && first_i) |=> (lanes_q.acc[LANES-1] == '0));
        end
    endgenerate

endmodule

// File: rtl/corr_drain.sv
// Holds a finished pass and presents one lane per cycle, lowest lag first.
module corr_drain #(
    parameter int ACC_W    = 40,
    parameter int LANES    = 4,
    parameter int NUM_LAGS = 16,
    localparam int LAG_W   = (NUM_LAGS > 1) ? $clog2(NUM_LAGS) : 1,
    localparam int IDX_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [LAG_W-1:0]             base_i,
    input  logic                         fin_i,
    input  logic [LANES-1:0][ACC_W-1:0]  sums_i,
    output logic                         out_valid,
    output logic [LAG_W-1:0]             out_lag,
    output logic [ACC_W-1:0]             out_data,
    output logic                         out_last
);

    typedef struct packed {
        logic                        valid;
        logic [IDX_W-1:0]            idx;
        logic [LAG_W-1:0]            base;
        logic                        fin;
        logic [LANES-1:0][ACC_W-1:0] hold;
    } drain_t;

    drain_t dr_d, dr_q;
    logic   at_end;

    assign at_end = (dr_q.idx == IDX_W'(LANES - 1));

    always_comb begin
        dr_d = dr_q;
        if (dr_q.valid) begin
            if (at_end) begin
                dr_d.valid = 1'b0;
            end else begin
                dr_d.idx = dr_q.idx + IDX_W'(1);
                for (int j = 0; j < LANES - 1; j++) begin
                    dr_d.hold[j] = dr_q.hold[j+1];
                end
                dr_d.hold[LANES-1] = '0;
            end
        end
        if (load_i) begin
            dr_d.valid = 1'b1;
            dr_d.idx   = '0;
            dr_d.base  = base_i;
            dr_d.fin   = fin_i;
            dr_d.hold  = sums_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q <= '0;
        end else begin
            dr_q <= dr_d;
        end
    end

    assign out_valid = dr_q.valid;
    assign out_lag   = dr_q.base + LAG_W'(dr_q.idx);
    assign out_data  = dr_q.hold[0];
    assign out_last  = dr_q.valid && dr_q.fin && at_end;

    // R3: inside one drain the lag climbs by exactly one per cycle
    p_lag_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(load_i))
            |-> (out_lag == LAG_W'($past(out_lag) + LAG_W'(1))));

    // R4: the end marker only accompanies the highest lag
    p_last_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && (out_lag == LAG_W'(NUM_LAGS - 1))));

endmodule

// File: rtl/corr_engine.sv
module corr_engine
    import corr_pkg::*;
#(
    parameter int DATA_W   = CORR_DATA_W,
    parameter int ACC_W    = CORR_ACC_W,
    parameter int SIG_LEN  = 32,
    parameter int LANES    = 4,
    parameter int NUM_LAGS = 16,
    localparam int LAG_W   = (NUM_LAGS > 1) ? $clog2(NUM_LAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_ref,
    input  logic [DATA_W-1:0] in_shf,
    output logic              out_valid,
    output logic [LAG_W-1:0]  out_lag,
    output logic [ACC_W-1:0]  out_data,
    output logic              out_last
);

    localparam int PASSES = NUM_LAGS / LANES;
    localparam int POS_W  = (SIG_LEN > 1) ? $clog2(SIG_LEN) : 1;
    localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [PASS_W-1:0] pass;
    } seq_t;

    seq_t       seq_d, seq_q;
    corr_step_t step;
    logic [LANES-1:0][DATA_W-1:0] taps;
    logic [LANES-1:0][ACC_W-1:0]  sums;
    logic [LAG_W-1:0]             pass_base;
    logic                         pass_fin;

    always_comb begin
        step.valid = in_valid;
        step.first = in_valid && (seq_q.pos == '0);
        step.last  = in_valid && (seq_q.pos == POS_W'(SIG_LEN - 1));

        seq_d = seq_q;
        if (step.last) begin
            seq_d.pos = '0;
            if (seq_q.pass == PASS_W'(PASSES - 1)) begin
                seq_d.pass = '0;
            end else begin
                seq_d.pass = seq_q.pass + PASS_W'(1);
            end
        end else if (step.valid) begin
            seq_d.pos = seq_q.pos + POS_W'(1);
        end

        pass_base = LAG_W'(int'(seq_q.pass) * LANES);
        pass_fin  = (seq_q.pass == PASS_W'(PASSES - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    corr_window #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (step.valid),
        .clear_i (step.first),
        .din_i   (in_shf),
        .taps_o  (taps)
    );

    corr_lanes #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .LANES  (LANES)
    ) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (step.valid),
        .first_i (step.first),
        .ref_i   (in_ref),
        .taps_i  (taps),
        .sums_o  (sums)
    );

    corr_drain #(
        .ACC_W    (ACC_W),
        .LANES    (LANES),
        .NUM_LAGS (NUM_LAGS)
    ) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (step.last),
        .base_i    (pass_base),
        .fin_i     (pass_fin),
        .sums_i    (sums),
        .out_valid (out_valid),
        .out_lag   (out_lag),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // R5: an idle input cycle leaves the pass position untouched
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(seq_q));

    // R3: results begin only right after a pass has been completed
    p_drain_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(step.last));

endmodule

// File: tb/corr_engine_test.sv
`timescale 1ns/1ps
module corr_engine_test;

    localparam int DW = 16;
    localparam int AW = 40;
    localparam int L  = 5;
    localparam int LN = 4;
    localparam int NL = 8;
    localparam int LW = $clog2(NL);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [DW-1:0]        in_ref = '0;
    logic [DW-1:0]        in_shf = '0;
    logic                 out_valid;
    logic [LW-1:0]        out_lag;
    logic signed [AW-1:0] out_data;
    logic                 out_last;

    always #2 clk = ~clk;

    corr_engine #(
        .DATA_W (DW), .ACC_W (AW), .SIG_LEN (L), .LANES (LN), .NUM_LAGS (NL)
    ) uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .in_ref (in_ref), .in_shf (in_shf),
        .out_valid (out_valid), .out_lag (out_lag),
        .out_data (out_data), .out_last (out_last)
    );

    int     total = 0;
    int     bad = 0;
    string  tag = "R1";
    int     xs [L];
    int     ys [L];
    longint q_val [$];
    int     q_lag [$];
    bit     q_last [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model: compare outputs against the expectation queue each cycle.
    task automatic compare_now();
        if (q_lag.size() > 0) begin
            chk(out_valid == 1'b1, "R3", {tag, " out_valid"}, longint'(out_valid), 1);
            chk(int'(out_lag) == q_lag[0], "R3", {tag, " out_lag"}, longint'(out_lag), q_lag[0]);
            chk(longint'(out_data) == q_val[0], "R2", {tag, " out_data"}, longint'(out_data), q_val[0]);
            chk(out_last == q_last[0], "R4", {tag, " out_last"}, longint'(out_last), longint'(q_last[0]));
            void'(q_val.pop_front());
            void'(q_lag.pop_front());
            void'(q_last.pop_front());
        end else begin
            chk(out_valid == 1'b0, tag, "idle out_valid", longint'(out_valid), 0);
            chk(out_last == 1'b0, tag, "idle out_last", longint'(out_last), 0);
        end
    endtask

    function automatic longint ref_corr(input int tau);
        longint s = 0;
        for (int n = 0; n < L; n++) begin
            if (n - tau >= 0 && n - tau < L) s += longint'(xs[n]) * longint'(ys[n - tau]);
        end
        return s;
    endfunction

    task automatic step(input bit v, input int a, input int b);
        @(negedge clk);
        compare_now();
        in_valid = v;
        in_ref   = DW'(a);
        in_shf   = DW'(b);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0);
    endtask

    // One full correlation: NL/LN passes, optional stall cycles with junk data (R5).
    task automatic run_corr(input int gap);
        for (int q = 0; q < NL / LN; q++) begin
            for (int k = 0; k < L; k++) begin
                for (int g = 0; g < gap; g++) step(1'b0, 12345 - g, -777 + g);
                step(1'b1, xs[k], (k - q * LN >= 0) ? ys[k - q * LN] : 0);
                if (k == L - 1) begin
                    for (int j = 0; j < LN; j++) begin
                        q_val.push_back(ref_corr(q * LN + j));
                        q_lag.push_back(q * LN + j);
                        q_last.push_back((q * LN + j) == NL - 1);
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: quiet outputs during and after reset
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "reset out_valid", longint'(out_valid), 0);
        rst_n = 1'b1;
        idle(3);

        // R2: ramp against falling ramp
        tag = "R2";
        for (int i = 0; i < L; i++) begin xs[i] = i + 1; ys[i] = L - i; end
        run_corr(0);
        idle(LN + 2);

        // R9: auto-correlation with mixed signs
        tag = "R9";
        xs = '{3, -7, 11, -2, 5};
        ys = xs;
        run_corr(0);
        idle(LN + 2);
        chk(ref_corr(0) == 208, "R9", "sum of squares model", ref_corr(0), 208);

        // R5: stall cycles with junk on both streams
        tag = "R5";
        xs = '{-4, 9, 0, 6, -1};
        ys = '{2, -3, 8, 1, 7};
        run_corr(2);
        idle(LN + 2);

        // R6: large tail in the shifted stream must not leak into the next pass
        tag = "R6";
        xs = '{1000, 1000, 1000, 1000, 1000};
        ys = '{0, 0, 0, 0, 30000};
        run_corr(0);
        idle(LN + 2);

        // R10: full-scale negative samples on both streams
        tag = "R10";
        for (int i = 0; i < L; i++) begin xs[i] = -32768; ys[i] = -32768; end
        run_corr(0);
        idle(LN + 2);
        chk(ref_corr(0) == 64'sd5368709120, "R10", "full-scale lag0 model",
            ref_corr(0), 64'sd5368709120);

        // R7 and R8: two correlations back to back, no idle cycles between passes
        tag = "R7";
        xs = '{5, -6, 7, -8, 9};
        ys = '{-1, 2, -3, 4, -5};
        run_corr(0);
        tag = "R8";
        xs = '{32767, -32768, 100, -100, 1};
        ys = '{-32768, 32767, 1, 2, 3};
        run_corr(0);
        idle(LN + 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule